// File: doc/BRIEF.md
# Bit-Packed Scan Match Engine

This block runs one scan command. A descriptor of eight 64-bit words comes in on a single wide input, together with a byte limit for the input buffer and one for the output buffer. The block checks the header for the command, the input and output formats, the element width and the criterion setup. It then reads packed input elements of 1, 2, 4 or 8 bits, one 64-bit word at a time, from a memory read port. Each element is compared with a criterion byte. The block produces one result bit per element and packs these bits into 512-bit lines, which it writes on a line write port.

Progress is reported through a two-byte completion record that software polls. The block writes a zero status as soon as it accepts a command. When it finishes, it writes a final status, and for errors an error code as well. A header it cannot run is reported as status 2 with a code that names the first failing check. In that case nothing is read and no line is written. The two limits cut the work short, so the block never reads or writes past the end of a buffer.

Top module: `scan_match_engine`

## Requirements
- R1: After reset the block is idle, with busy_o, rd_req_o, wr_en_o and cmp_we_o all low. start_i is taken only while busy_o is low. At that edge the block samples the descriptor and both limits. Word k of the descriptor sits in desc_i[64k+63:64k], in this order: control, completion address, primary input address, access control, secondary input address, operation data, output address, table address. Later changes to start_i, desc_i or the limits have no effect until the command ends.
- R2: In the cycle after a command is accepted, the block writes 16'h0000 to the completion address. cmp_data_o[7:0] is the status and cmp_data_o[15:8] is the error code. busy_o stays high from the accepted start until the cycle after the final completion write.
- R3: The control word is checked in this priority order, and the first failure gives the error code:
  - opcode [55:48] must be 2, else code 1;
  - input format [31:28] must be 1, else code 2;
  - element size [27:23] must be 0, 1, 3 or 7, else code 3;
  - output format [13:10] must be 8, else code 4;
  - criterion size [9:5] must be 0 and second criterion [4:0] must be 31, else code 5;
  - access word [25:24] must be 2, else code 6.

  On an error the final completion data is {code, 8'd2}, and no read or line write takes place.
- R4: The element width is the element-size field plus one. Each element is zero-extended and compared with the criterion byte in operation data [63:56]. An equal element gives a 1 bit and any other element gives a 0 bit. A criterion larger than any element value therefore gives all zeros.
- R5: Input is read as 64-bit words, starting at the primary address with bits [2:0] cleared and stepping by 8. Elements run from the most significant bits of each word downward. Only one read is in flight at a time, and rd_data_i is taken in the cycle after rd_req_o.
- R6: Within a line, the result of the line's element k sits at wr_data_o[511-k]. That is bit 7 of byte 0 when byte 0 is wr_data_o[511:504].
- R7: Lines are written to the output address with bits [5:0] cleared, each line 64 bytes after the one before. The last line, if only partly filled, is padded with zero bits.
- R8: Access word bits [23:0] hold the input length in bits minus one. The element count is the bit count divided by the width, rounded down.
- R9: The number of input bits used is capped at 8 * in_lim_i.
- R10: The element count is capped at 512 * floor(out_lim_i / 64), so no line reaches past the output base plus out_lim_i. With a cap of zero, no line is written and the command still succeeds.
- R11: After the last line, or straight after the zero write when there is no work, a successful command writes {8'd0, 8'd1} to the completion address. busy_o falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a command (taken while idle) |
| desc_i | input | 512 | Eight descriptor words, word 0 in the low bits |
| in_lim_i | input | LIM_W | Input buffer limit in bytes |
| out_lim_i | input | LIM_W | Output buffer limit in bytes |
| busy_o | output | 1 | Command in progress |
| rd_req_o | output | 1 | Input word read request |
| rd_addr_o | output | 64 | Input word byte address |
| rd_data_i | input | 64 | Read data, valid one cycle after the request |
| wr_en_o | output | 1 | Output line write |
| wr_addr_o | output | 64 | Output line byte address |
| wr_data_o | output | 512 | Output line data |
| cmp_we_o | output | 1 | Completion record write |
| cmp_addr_o | output | 64 | Completion record address |
| cmp_data_o | output | 16 | {error code, status} |

## Verification
The zero completion write is due in the cycle after the edge that accepts the command. The bench checks it at the falling edge of that cycle. Read data is returned one edge after each request, and a line appears in the cycle after its last element is scanned. The final completion write follows the cycle after the last line, or the cycle after the zero write when there is no work. A behavioural model predicts the ordered list of line writes and completion writes from the memory contents and the descriptor, and every falling edge compares any write on the ports against the head of that list. Unexpected writes and missing writes both count as failures.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_FETCH, ST_WAIT, ST_SCAN, ST_FLUSH, ST_CLOSE
  } scan_st_e;

  localparam logic [7:0] OPC_SCAN_VAL = 8'd2;
  localparam logic [3:0] IFMT_PACKED  = 4'd1;
  localparam logic [3:0] OFMT_BITVEC  = 4'd8;
  localparam logic [1:0] LFMT_BITS    = 2'd2;
  localparam logic [4:0] CRIT2_OFF    = 5'd31;

  localparam logic [7:0] ERR_NONE = 8'd0;
  localparam logic [7:0] ERR_OPC  = 8'd1;
  localparam logic [7:0] ERR_IFMT = 8'd2;
  localparam logic [7:0] ERR_ESZ  = 8'd3;
  localparam logic [7:0] ERR_OFMT = 8'd4;
  localparam logic [7:0] ERR_CRIT = 8'd5;
  localparam logic [7:0] ERR_LFMT = 8'd6;

  localparam logic [7:0] CST_OK  = 8'd1;
  localparam logic [7:0] CST_ERR = 8'd2;
endpackage

// File: rtl/scan_hdr_dec.sv
module scan_hdr_dec
  import scan_pkg::*;
(
  input  logic [63:0] ctrl_i,
  input  logic [1:0]  lfmt_i,
  output logic [7:0]  err_o,
  output logic [1:0]  wlog_o
);
  logic esz_ok;

  always_comb begin
    esz_ok = 1'b1;
    unique case (ctrl_i[27:23])
      5'd0:    wlog_o = 2'd0;
      5'd1:    wlog_o = 2'd1;
      5'd3:    wlog_o = 2'd2;
      5'd7:    wlog_o = 2'd3;
      default: begin wlog_o = 2'd0; esz_ok = 1'b0; end
    endcase
  end

  always_comb begin
    if (ctrl_i[55:48] != OPC_SCAN_VAL)                           err_o = ERR_OPC;
    else if (ctrl_i[31:28] != IFMT_PACKED)                       err_o = ERR_IFMT;
    else if (!esz_ok)                                            err_o = ERR_ESZ;
    else if (ctrl_i[13:10] != OFMT_BITVEC)                       err_o = ERR_OFMT;
    else if (ctrl_i[9:5] != 5'd0 || ctrl_i[4:0] != CRIT2_OFF)    err_o = ERR_CRIT;
    else if (lfmt_i != LFMT_BITS)                                err_o = ERR_LFMT;
    else                                                         err_o = ERR_NONE;
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[63:56], ctrl_i[47:32], ctrl_i[22:14]};
endmodule

// File: rtl/scan_elem_cmp.sv
module scan_elem_cmp (
  input  logic [7:0] top_i,
  input  logic [1:0] wlog_i,
  input  logic [7:0] crit_i,
  output logic       hit_o
);
  logic [3:0] sh;
  logic [7:0] elem;

  // element occupies the top W bits; right-align it
  assign sh    = 4'd8 - (4'd1 << wlog_i);
  assign elem  = top_i >> sh;
  assign hit_o = (elem == crit_i);
endmodule

// File: rtl/scan_line_pack.sv
module scan_line_pack #(
  parameter int LINE_BITS = 512,
  localparam int CW = $clog2(LINE_BITS) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 push_i,
  input  logic                 bit_i,
  output logic [LINE_BITS-1:0] line_o,
  output logic [CW-1:0]        cnt_o
);
  logic [LINE_BITS-1:0] sreg_q;
  logic [CW-1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (push_i) begin
      sreg_q <= {sreg_q[LINE_BITS-2:0], bit_i};
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  // left-justify so the first pushed bit lands at the MSB; tail is zero
  assign line_o = sreg_q << (CW'(LINE_BITS) - cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/scan_match_engine.sv
module scan_match_engine
  import scan_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int LIM_W     = 20,
  parameter int LINE_BITS = 512,
  localparam int LINE_BYTES = LINE_BITS / 8,
  localparam int LB_LOG     = $clog2(LINE_BYTES),
  localparam int LL_LOG     = $clog2(LINE_BITS),
  localparam int CW         = LL_LOG + 1,
  localparam int EW         = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [511:0]         desc_i,
  input  logic [LIM_W-1:0]     in_lim_i,
  input  logic [LIM_W-1:0]     out_lim_i,
  output logic                 busy_o,
  output logic                 rd_req_o,
  output logic [63:0]          rd_addr_o,
  input  logic [63:0]          rd_data_i,
  output logic                 wr_en_o,
  output logic [63:0]          wr_addr_o,
  output logic [LINE_BITS-1:0] wr_data_o,
  output logic                 cmp_we_o,
  output logic [63:0]          cmp_addr_o,
  output logic [15:0]          cmp_data_o
);
  logic [63:0] ctrl_w, cmpa_w, in0_w, acc_w, opd_w, out_w;
  assign ctrl_w = desc_i[0*64 +: 64];
  assign cmpa_w = desc_i[1*64 +: 64];
  assign in0_w  = desc_i[2*64 +: 64];
  assign acc_w  = desc_i[3*64 +: 64];
  assign opd_w  = desc_i[5*64 +: 64];
  assign out_w  = desc_i[6*64 +: 64];

  logic [7:0] dec_err;
  logic [1:0] dec_wlog;

  scan_hdr_dec u_dec (
    .ctrl_i (ctrl_w),
    .lfmt_i (acc_w[25:24]),
    .err_o  (dec_err),
    .wlog_o (dec_wlog)
  );

  // element count at start: min(length, input cap) / width, then output cap
  logic [EW-1:0] bits_req, bits_lim, bits_min, ne_in, ne_out, ne_all;
  always_comb begin
    bits_req = EW'(acc_w[LEN_W-1:0]) + EW'(1);
    bits_lim = EW'(in_lim_i) << 3;
    bits_min = (bits_req < bits_lim) ? bits_req : bits_lim;
    ne_in    = bits_min >> dec_wlog;
    ne_out   = EW'(out_lim_i >> LB_LOG) << LL_LOG;
    ne_all   = (ne_in < ne_out) ? ne_in : ne_out;
  end

  scan_st_e       st_q;
  logic [7:0]     err_q, crit_q;
  logic [1:0]     wlog_q;
  logic [63:0]    rd_ptr_q, wr_ptr_q, cmp_addr_q, word_q;
  logic [EW-1:0]  ne_q, ecnt_q;
  logic [6:0]     wbits_q, wstep;
  logic           hit;
  logic [CW-1:0]  pack_cnt;
  logic           pack_full, last_elem, word_done;

  assign wstep     = 7'd1 << wlog_q;
  assign pack_full = (pack_cnt == CW'(LINE_BITS - 1));
  assign last_elem = (ecnt_q + EW'(1) == ne_q);
  assign word_done = (wbits_q + wstep == 7'd64);

  scan_elem_cmp u_cmp (
    .top_i  (word_q[63:56]),
    .wlog_i (wlog_q),
    .crit_i (crit_q),
    .hit_o  (hit)
  );

  scan_line_pack #(.LINE_BITS(LINE_BITS)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_FLUSH),
    .push_i (st_q == ST_SCAN),
    .bit_i  (hit),
    .line_o (wr_data_o),
    .cnt_o  (pack_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      err_q      <= '0;
      crit_q     <= '0;
      wlog_q     <= '0;
      rd_ptr_q   <= '0;
      wr_ptr_q   <= '0;
      cmp_addr_q <= '0;
      word_q     <= '0;
      ne_q       <= '0;
      ecnt_q     <= '0;
      wbits_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          err_q      <= dec_err;
          wlog_q     <= dec_wlog;
          crit_q     <= opd_w[63:56];
          rd_ptr_q   <= {in0_w[63:3], 3'b0};
          wr_ptr_q   <= {out_w[63:6], 6'b0};
          cmp_addr_q <= cmpa_w;
          ne_q       <= ne_all;
          ecnt_q     <= '0;
          st_q       <= ST_OPEN;
        end
        ST_OPEN:  st_q <= (err_q != ERR_NONE || ne_q == '0) ? ST_CLOSE : ST_FETCH;
        ST_FETCH: begin
          rd_ptr_q <= rd_ptr_q + 64'd8;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          word_q  <= rd_data_i;
          wbits_q <= '0;
          st_q    <= ST_SCAN;
        end
        ST_SCAN: begin
          word_q  <= word_q << wstep;
          wbits_q <= wbits_q + wstep;
          ecnt_q  <= ecnt_q + EW'(1);
          if (last_elem || pack_full) st_q <= ST_FLUSH;
          else if (word_done)         st_q <= ST_FETCH;
        end
        ST_FLUSH: begin
          wr_ptr_q <= wr_ptr_q + 64'(LINE_BYTES);
          if (ecnt_q == ne_q)          st_q <= ST_CLOSE;
          else if (wbits_q == 7'd64)   st_q <= ST_FETCH;
          else                         st_q <= ST_SCAN;
        end
        ST_CLOSE: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign rd_req_o   = (st_q == ST_FETCH);
  assign rd_addr_o  = rd_ptr_q;
  assign wr_en_o    = (st_q == ST_FLUSH);
  assign wr_addr_o  = wr_ptr_q;
  assign cmp_we_o   = (st_q == ST_OPEN) || (st_q == ST_CLOSE);
  assign cmp_addr_o = cmp_addr_q;
  assign cmp_data_o = (st_q == ST_CLOSE)
                    ? {err_q, (err_q != ERR_NONE) ? CST_ERR : CST_OK}
                    : 16'h0000;

  logic unused_desc;
  assign unused_desc = ^{desc_i[319:256], desc_i[511:448], acc_w[63:26],
                         acc_w[23:LEN_W], opd_w[55:0], in0_w[2:0], out_w[5:0]};
endmodule

// File: rtl/scan_match_engine_chk.sv
module scan_match_engine_chk #(
  parameter int LIM_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             rd_req_o,
  input logic             wr_en_o,
  input logic [63:0]      wr_addr_o,
  input logic             cmp_we_o,
  input logic [7:0]       cmp_status_i,
  input logic [57:0]      out_base_i,
  input logic [LIM_W-1:0] out_lim_i
);
  logic [63:0] base_q, lim_q;
  logic [15:0] lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      lim_q   <= '0;
      lines_q <= '0;
    end else if (start_i && !busy_o) begin
      base_q  <= {out_base_i, 6'b0};
      lim_q   <= 64'(out_lim_i);
      lines_q <= '0;
    end else if (wr_en_o) begin
      lines_q <= lines_q + 16'd1;
    end
  end

  // R2
  open_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (cmp_we_o && cmp_status_i == 8'd0));

  // R3
  err_no_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_o && cmp_status_i == 8'd2) |-> (lines_q == 16'd0));

  // R5
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R7
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[5:0] == 6'd0));

  // R10
  out_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_addr_o + 64'd64 - base_q) <= lim_q));

  // R11
  close_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(cmp_we_o) && $past(cmp_status_i) != 8'd0));

  // R1
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wr_en_o && !rd_req_o));
endmodule

bind scan_match_engine scan_match_engine_chk #(.LIM_W(LIM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .rd_req_o     (rd_req_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .cmp_we_o     (cmp_we_o),
  .cmp_status_i (cmp_data_o[7:0]),
  .out_base_i   (desc_i[447:390]),
  .out_lim_i    (out_lim_i)
);

// File: tb/scan_match_engine_tb.sv
module scan_match_engine_tb;
  localparam int LIM_W = 20;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [511:0]     desc_i = '0;
  logic [LIM_W-1:0] in_lim_i = '0;
  logic [LIM_W-1:0] out_lim_i = '0;
  logic             busy_o, rd_req_o, wr_en_o, cmp_we_o;
  logic [63:0]      rd_addr_o, wr_addr_o, cmp_addr_o;
  logic [63:0]      rd_data_i = '0;
  logic [511:0]     wr_data_o;
  logic [15:0]      cmp_data_o;

  always #10 clk_i = ~clk_i;

  scan_match_engine #(.LIM_W(LIM_W)) u_dut (.*);

  logic [63:0] mem [0:255];
  always @(posedge clk_i) if (rd_req_o) rd_data_i <= mem[rd_addr_o[10:3]];

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  logic [63:0]  exp_la_q[$];
  logic [511:0] exp_ld_q[$];
  logic [63:0]  exp_ca_q[$];
  logic [15:0]  exp_cd_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog %s act=%0d exp=%0d", cur_req, cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // compare every write on the ports against the predicted order
  always @(negedge clk_i) if (rst_ni) begin
    if (wr_en_o) begin
      if (exp_la_q.size() == 0) chk(0, cur_req, "unexpected line", wr_addr_o, 0);
      else begin
        chk(wr_addr_o == exp_la_q[0], cur_req, "line addr", wr_addr_o, exp_la_q[0]);
        chk(wr_data_o == exp_ld_q[0], cur_req, "line data", wr_data_o, exp_ld_q[0]);
        void'(exp_la_q.pop_front());
        void'(exp_ld_q.pop_front());
      end
    end
    if (cmp_we_o) begin
      if (exp_cd_q.size() == 0) chk(0, cur_req, "unexpected completion", cmp_data_o, 0);
      else begin
        chk(cmp_addr_o == exp_ca_q[0], cur_req, "completion addr", cmp_addr_o, exp_ca_q[0]);
        chk(cmp_data_o == exp_cd_q[0], cur_req, "completion data", cmp_data_o, exp_cd_q[0]);
        void'(exp_ca_q.pop_front());
        void'(exp_cd_q.pop_front());
      end
    end
  end

  function automatic logic [63:0] mk_ctrl(int opc, int ifmt, int esz, int ofmt, int csz, int c2);
    return (64'(opc) << 48) | (64'(ifmt) << 28) | (64'(esz) << 23) |
           (64'(ofmt) << 10) | (64'(csz) << 5) | 64'(c2);
  endfunction

  function automatic logic [63:0] mk_acc(int lfmt, int nbits);
    return (64'(lfmt) << 24) | 64'(nbits - 1);
  endfunction

  task automatic predict(input logic [63:0] ctrl, acc, opd, in_a, out_a, cmp_a,
                         input int inl, outl);
    int code, wl, w, bits, n, b, o, cap;
    logic [63:0] word, el;
    logic [511:0] line;
    code = 0;
    case (ctrl[27:23])
      5'd0: wl = 0;
      5'd1: wl = 1;
      5'd3: wl = 2;
      5'd7: wl = 3;
      default: wl = -1;
    endcase
    if (ctrl[55:48] != 8'd2) code = 1;
    else if (ctrl[31:28] != 4'd1) code = 2;
    else if (wl < 0) code = 3;
    else if (ctrl[13:10] != 4'd8) code = 4;
    else if (ctrl[9:5] != 5'd0 || ctrl[4:0] != 5'd31) code = 5;
    else if (acc[25:24] != 2'd2) code = 6;
    exp_ca_q.push_back(cmp_a); exp_cd_q.push_back(16'h0000);
    if (code != 0) begin
      exp_ca_q.push_back(cmp_a); exp_cd_q.push_back({code[7:0], 8'd2});
      return;
    end
    w = 1 << wl;
    bits = int'(acc[23:0]) + 1;
    if (inl * 8 < bits) bits = inl * 8;
    n = bits >> wl;
    cap = (outl / 64) * 512;
    if (n > cap) n = cap;
    line = '0;
    for (int e = 0; e < n; e++) begin
      b = e * w;
      o = b % 64;
      word = mem[int'(in_a >> 3) + b / 64];
      el = (word >> (64 - o - w)) & ((64'd1 << w) - 64'd1);
      line[511 - (e % 512)] = (el == 64'(opd[63:56]));
      if (e % 512 == 511 || e == n - 1) begin
        exp_la_q.push_back((out_a & ~64'd63) + 64'(64 * (e / 512)));
        exp_ld_q.push_back(line);
        line = '0;
      end
    end
    exp_ca_q.push_back(cmp_a); exp_cd_q.push_back(16'h0001);
  endtask

  task automatic run(input string req, input logic [63:0] ctrl, acc, opd, in_a, out_a, cmp_a,
                     input int inl, outl, input bit poke);
    cur_req = req;
    predict(ctrl, acc, opd, in_a, out_a, cmp_a, inl, outl);
    @(negedge clk_i);
    desc_i = {64'hDEAD, out_a, opd, 64'hBEEF, acc, in_a, cmp_a, ctrl};
    in_lim_i = inl[LIM_W-1:0];
    out_lim_i = outl[LIM_W-1:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2: zero status due in the cycle after the accepting edge
    chk(cmp_we_o && cmp_data_o == 16'h0 && busy_o, "R2", "open write", {cmp_we_o, cmp_data_o}, 17'h10000);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      desc_i = '1; in_lim_i = '0; out_lim_i = '0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    // R11: every predicted write, including final status, has been seen
    chk(exp_la_q.size() == 0 && exp_cd_q.size() == 0 && !busy_o, "R11",
        {req, " writes outstanding"}, exp_la_q.size() + exp_cd_q.size(), 0);
  endtask

  logic [63:0] good1, good2, good4, good8;

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [63:0] v;
      v = 64'(i + 1) * 64'h9E3779B97F4A7C15;
      mem[i] = v ^ (v >> 29);
    end
    mem[40] = 64'hF0F0_3C3C_0000_FFFF;
    good1 = mk_ctrl(2, 1, 0, 8, 0, 31);
    good2 = mk_ctrl(2, 1, 1, 8, 0, 31);
    good4 = mk_ctrl(2, 1, 3, 8, 0, 31);
    good8 = mk_ctrl(2, 1, 7, 8, 0, 31);

    repeat (3) @(negedge clk_i);
    chk(!busy_o && !rd_req_o && !wr_en_o && !cmp_we_o, "R1", "reset outputs",
        {busy_o, rd_req_o, wr_en_o, cmp_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !cmp_we_o, "R1", "idle after reset", {busy_o, cmp_we_o}, 0);

    // R4 R6 R7: 1-bit elements vs 0, padded partial line
    run("R4", good1, mk_acc(2, 100), 64'h0, 64'h100, 64'h4000, 64'h8000, 4096, 4096, 0);
    // R5 R6: 600 bits over several words, two lines, misaligned bases
    run("R5", good1, mk_acc(2, 600), 64'h0100_0000_0000_0000, 64'h10B, 64'h5027, 64'h8010, 4096, 4096, 0);
    run("R6", good2, mk_acc(2, 70), 64'h0200_0000_0000_0000, 64'h200, 64'h6000, 64'h8020, 4096, 4096, 0);
    run("R4", good4, mk_acc(2, 256), 64'h0500_0000_0000_0000, 64'h300, 64'h7000, 64'h8030, 4096, 4096, 0);
    // R8: 130 bits of 8-bit elements -> 16 elements, known word present
    run("R8", good8, mk_acc(2, 130), 64'h3C00_0000_0000_0000, 64'h140, 64'h7400, 64'h8040, 4096, 4096, 0);
    // R4: criterion above any 1-bit value
    run("R4", good1, mk_acc(2, 64), 64'h0300_0000_0000_0000, 64'h140, 64'h7800, 64'h8050, 4096, 4096, 0);
    // R7: exactly one full line
    run("R7", good1, mk_acc(2, 512), 64'h0, 64'h400, 64'h7C00, 64'h8060, 4096, 4096, 0);
    // R9: input cap of 4 bytes
    run("R9", good1, mk_acc(2, 200), 64'h0, 64'h500, 64'h9000, 64'h8070, 4, 4096, 0);
    // R10: output cap of one line, then zero
    run("R10", good1, mk_acc(2, 1000), 64'h0100_0000_0000_0000, 64'h600, 64'hA000, 64'h8080, 4096, 100, 0);
    run("R10", good1, mk_acc(2, 50), 64'h0, 64'h600, 64'hA400, 64'h8090, 4096, 0, 0);
    // R3: every error code and one priority case
    run("R3", mk_ctrl(3, 1, 0, 8, 0, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(5, 2, 2, 0, 0, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(2, 0, 0, 8, 0, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(2, 1, 2, 8, 0, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(2, 1, 0, 7, 0, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(2, 1, 0, 8, 1, 31), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", mk_ctrl(2, 1, 0, 8, 0, 0), mk_acc(2, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    run("R3", good1, mk_acc(1, 64), 0, 64'h100, 64'hB000, 64'h80A0, 4096, 4096, 0);
    // R1: start and new descriptor while busy have no effect
    run("R1", good2, mk_acc(2, 900), 64'h0100_0000_0000_0000, 64'h100, 64'hC000, 64'h80B0, 4096, 4096, 1);
    // R2: back-to-back command after a poke run still opens normally
    run("R2", good8, mk_acc(2, 64), 64'h0F00_0000_0000_0000, 64'h140, 64'hD000, 64'h80C0, 4096, 4096, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule